// File: doc/BRIEF.md
# Hiccup Overcurrent Protection Controller

This block sequences overload protection for a switching regulator. Each switching period delivers one tick strobe together with a flag saying whether the cycle-by-cycle current limit fired in that period. Once soft start has completed and the output has risen past half of its target, the controller arms and counts limit incidents. A short run of clean periods is tolerated; only four clean ticks in a row wipe the tally.

When the tally reaches the trip count and hiccup operation is enabled, both gate drivers are disabled and soft start is held discharged. An off-time timer then counts switching ticks. When the timer expires, the hold is released, the regulator ramps up again, and the controller returns to its disarmed state. Clearing the enable bit during the off time shortens the wait to one more tick. The analog comparators, the soft-start ramp and the configuration register live outside this block.

Top module: `hiccup_ctrl`

## Requirements
- R1: After reset the block is disarmed. `event_cnt` is 0 and `armed`, `drv_disable`, `ss_hold` and `fault_active` are all 0.
- R2: The block arms only on a clock where `cyc_tick`, `ss_done` and `vout_half` are all 1. While disarmed, no incident is counted and `event_cnt` reads 0 from the clock after it becomes disarmed.
- R3: While armed, a tick with `ilim_hit`=1 adds one to `event_cnt`, as long as `ss_done` and `vout_half` are both 1. The count saturates at TRIP_COUNT.
- R4: CLEAN_RUN (default 4) consecutive armed ticks with `ilim_hit`=0 clear `event_cnt` to 0. A tick with `ilim_hit`=1 restarts the clean run, so fewer clean ticks followed by a hit let the count continue.
- R5: When `event_cnt` equals TRIP_COUNT while armed and `hiccup_en`=1, the next clock raises `drv_disable`, `ss_hold` and `fault_active` and drops `armed`.
- R6: The shutdown lasts exactly OFF_TICKS ticks. On the clock of the last tick, `drv_disable`, `ss_hold` and `fault_active` fall together.
- R7: With `hiccup_en`=0 the block never shuts down. The count still saturates at TRIP_COUNT.
- R8: If `hiccup_en` is 0 on a tick during the shutdown, the shutdown ends on that tick.
- R9: After a restart the block is disarmed with `event_cnt` 0 and must re-arm under R2 before it counts again.
- R10: An armed tick with `ss_done`=0 or `vout_half`=0 disarms the block without counting.
- R11: Counters move only on clocks with `cyc_tick`=1. Clocks without a tick leave `event_cnt` and the off-time progress unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | One-clock strobe per switching period |
| ilim_hit | input | 1 | Current limit fired in this period (valid with tick) |
| ss_done | input | 1 | Soft start has finished |
| vout_half | input | 1 | Output is above half of its setpoint |
| hiccup_en | input | 1 | Enables the hiccup shutdown |
| drv_disable | output | 1 | Forces both gate drivers off |
| ss_hold | output | 1 | Holds soft start discharged |
| fault_active | output | 1 | High for the whole shutdown interval |
| armed | output | 1 | Incident counting is active |
| event_cnt | output | $clog2(TRIP_COUNT+1) | Current incident tally |

## Verification
On every cycle, the assertions check these properties:
- the count never exceeds the trip level and advances by at most one per clock;
- the count holds still between ticks;
- the count reads zero while disarmed;
- a shutdown starts only from a full count with the enable set;
- a shutdown ends only on a tick, and ends on the next tick once the enable is cleared.

Only the bench scenarios can show the following:
- the exact length of the off time;
- the tolerance of up to three clean periods before a hit;
- re-arming after a restart;
- disarming when the rails drop out.

// File: rtl/hic_pkg.sv
package hic_pkg;
  typedef enum logic [1:0] {
    HIC_DISARMED = 2'd0,
    HIC_ARMED    = 2'd1,
    HIC_OFF      = 2'd2
  } hic_state_e;
endpackage

// File: rtl/hic_incident_cnt.sv
module hic_incident_cnt #(
  parameter int TRIP_COUNT = 512,
  parameter int CLEAN_RUN  = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                tick,
  input  logic                                count_en,
  input  logic                                clear,
  input  logic                                ilim_hit,
  output logic [$clog2(TRIP_COUNT+1)-1:0]     cnt,
  output logic                                at_limit
);
  localparam int CNT_W   = $clog2(TRIP_COUNT + 1);
  localparam int CLEAN_W = $clog2(CLEAN_RUN + 1);
  localparam logic [CNT_W-1:0]   TRIP_V       = CNT_W'(TRIP_COUNT);
  localparam logic [CLEAN_W-1:0] CLEAN_LAST_V = CLEAN_W'(CLEAN_RUN - 1);

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [CLEAN_W-1:0] clean_q, clean_d;
  logic               step_en;

  assign step_en = count_en & tick;

  always_comb begin
    cnt_d   = cnt_q;
    clean_d = clean_q;
    if (clear) begin
      cnt_d   = '0;
      clean_d = '0;
    end else if (step_en) begin
      if (ilim_hit) begin
        clean_d = '0;
        if (cnt_q != TRIP_V) cnt_d = cnt_q + 1'b1;
      end else if (clean_q == CLEAN_LAST_V) begin
        clean_d = '0;
        cnt_d   = '0;
      end else begin
        clean_d = clean_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      clean_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      clean_q <= clean_d;
    end
  end

  assign cnt      = cnt_q;
  assign at_limit = (cnt_q == TRIP_V);
endmodule

// File: rtl/hic_offtime_timer.sv
module hic_offtime_timer #(
  parameter int OFF_TICKS = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  output logic done
);
  localparam int OFF_W = (OFF_TICKS > 1) ? $clog2(OFF_TICKS) : 1;
  localparam logic [OFF_W-1:0] LAST_V = OFF_W'(OFF_TICKS - 1);

  logic [OFF_W-1:0] tmr_q, tmr_d;
  logic             last_tick;

  assign last_tick = run & tick & (tmr_q == LAST_V);

  always_comb begin
    tmr_d = tmr_q;
    if (!run || last_tick) tmr_d = '0;
    else if (tick)         tmr_d = tmr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

  assign done = last_tick;
endmodule

// File: rtl/hic_fsm.sv
module hic_fsm
  import hic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rails_ok,
  input  logic       at_limit,
  input  logic       hiccup_en,
  input  logic       off_done,
  output hic_state_e state
);
  hic_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HIC_DISARMED: if (tick && rails_ok) state_d = HIC_ARMED;
      HIC_ARMED: begin
        if (at_limit && hiccup_en)  state_d = HIC_OFF;
        else if (tick && !rails_ok) state_d = HIC_DISARMED;
      end
      HIC_OFF: if (tick && (!hiccup_en || off_done)) state_d = HIC_DISARMED;
      default: state_d = HIC_DISARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HIC_DISARMED;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/hiccup_ctrl.sv
module hiccup_ctrl
  import hic_pkg::*;
#(
  parameter int TRIP_COUNT = 512,
  parameter int CLEAN_RUN  = 4,
  parameter int OFF_TICKS  = 16384
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cyc_tick,
  input  logic                            ilim_hit,
  input  logic                            ss_done,
  input  logic                            vout_half,
  input  logic                            hiccup_en,
  output logic                            drv_disable,
  output logic                            ss_hold,
  output logic                            fault_active,
  output logic                            armed,
  output logic [$clog2(TRIP_COUNT+1)-1:0] event_cnt
);
  hic_state_e state;
  logic       rails_ok;
  logic       at_limit;
  logic       off_done;
  logic       in_off;

  assign rails_ok = ss_done & vout_half;
  assign in_off   = (state == HIC_OFF);

  hic_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (cyc_tick),
    .rails_ok  (rails_ok),
    .at_limit  (at_limit),
    .hiccup_en (hiccup_en),
    .off_done  (off_done),
    .state     (state)
  );

  hic_incident_cnt #(
    .TRIP_COUNT (TRIP_COUNT),
    .CLEAN_RUN  (CLEAN_RUN)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (cyc_tick),
    .count_en ((state == HIC_ARMED) && rails_ok),
    .clear    (state == HIC_DISARMED),
    .ilim_hit (ilim_hit),
    .cnt      (event_cnt),
    .at_limit (at_limit)
  );

  hic_offtime_timer #(
    .OFF_TICKS (OFF_TICKS)
  ) u_off (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (cyc_tick),
    .run   (in_off),
    .done  (off_done)
  );

  assign drv_disable  = in_off;
  assign ss_hold      = in_off;
  assign fault_active = in_off;
  assign armed        = (state == HIC_ARMED);
endmodule

// File: rtl/hiccup_ctrl_chk.sv
module hiccup_ctrl_chk #(
  parameter int TRIP_COUNT = 512
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            cyc_tick,
  input logic                            hiccup_en,
  input logic                            fault_active,
  input logic                            armed,
  input logic [$clog2(TRIP_COUNT+1)-1:0] event_cnt
);
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(event_cnt) <= TRIP_COUNT);

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> (event_cnt == '0 || int'(event_cnt) <= int'($past(event_cnt)) + 1));

  assert_hold_between_ticks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !cyc_tick) |=> $stable(event_cnt));

  assert_zero_when_disarmed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !fault_active) |=> (event_cnt == '0));

  assert_entry_needs_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_active ##1 fault_active) |-> (int'($past(event_cnt)) == TRIP_COUNT && $past(hiccup_en)));

  assert_exit_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_active && !cyc_tick) |=> fault_active);

  assert_abort_on_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_active && cyc_tick && !hiccup_en) |=> !fault_active);
endmodule

bind hiccup_ctrl hiccup_ctrl_chk #(.TRIP_COUNT(TRIP_COUNT)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cyc_tick     (cyc_tick),
  .hiccup_en    (hiccup_en),
  .fault_active (fault_active),
  .armed        (armed),
  .event_cnt    (event_cnt)
);

// File: tb/hiccup_ctrl_tb_top.sv
`timescale 1ns/1ps
module hiccup_ctrl_tb_top;
  localparam int TRIP = 8;
  localparam int CLEAN = 4;
  localparam int OFFT = 32;
  localparam int CW = $clog2(TRIP + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic cyc_tick, ilim_hit, ss_done, vout_half, hiccup_en;
  logic drv_disable, ss_hold, fault_active, armed;
  logic [CW-1:0] event_cnt;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  // reference state: 0 disarmed, 1 armed, 2 shutdown
  int m_st, m_cnt, m_clean, m_off;

  always #2.5 clk = ~clk;

  hiccup_ctrl #(.TRIP_COUNT(TRIP), .CLEAN_RUN(CLEAN), .OFF_TICKS(OFFT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .ilim_hit(ilim_hit),
    .ss_done(ss_done), .vout_half(vout_half), .hiccup_en(hiccup_en),
    .drv_disable(drv_disable), .ss_hold(ss_hold), .fault_active(fault_active),
    .armed(armed), .event_cnt(event_cnt)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit rails();
    return ss_done && vout_half;
  endfunction

  // reference update for one clock edge, using the inputs held during it
  task automatic model_step();
    int st = m_st;
    int cnt = m_cnt;
    int cl = m_clean;
    int off = m_off;
    if (st == 0) begin
      cnt = 0; cl = 0;
    end else if (st == 1 && cyc_tick && rails()) begin
      if (ilim_hit) begin
        cl = 0;
        if (m_cnt < TRIP) cnt = m_cnt + 1;
      end else if (m_clean == CLEAN - 1) begin
        cl = 0; cnt = 0;
      end else cl = m_clean + 1;
    end
    if (st != 2) off = 0;
    else if (cyc_tick) off = (m_off == OFFT - 1) ? 0 : m_off + 1;
    case (m_st)
      0: if (cyc_tick && rails()) st = 1;
      1: if (m_cnt == TRIP && hiccup_en) st = 2;
         else if (cyc_tick && !rails()) st = 0;
      default: if (cyc_tick && (!hiccup_en || m_off == OFFT - 1)) st = 0;
    endcase
    m_st = st; m_cnt = cnt; m_clean = cl; m_off = off;
  endtask

  task automatic compare_all();
    check("R3 event_cnt vs reference", int'(event_cnt), m_cnt);
    check("R2 armed vs reference", int'(armed), int'(m_st == 1));
    check("R5 fault_active vs reference", int'(fault_active), int'(m_st == 2));
    check("R5 drv_disable vs reference", int'(drv_disable), int'(m_st == 2));
    check("R6 ss_hold vs reference", int'(ss_hold), int'(m_st == 2));
  endtask

  // caller stands at a negedge; drive, let one edge pass, compare
  task automatic cyc(input logic t, input logic il);
    cyc_tick = t;
    ilim_hit = il;
    @(negedge clk);
    model_step();
    compare_all();
  endtask

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seed_sink;
    bit burst;
    seed_sink = $urandom(32'd20260);
    rst_n = 1'b0; cyc_tick = 0; ilim_hit = 0; ss_done = 0; vout_half = 0; hiccup_en = 1;
    m_st = 0; m_cnt = 0; m_clean = 0; m_off = 0;
    repeat (3) @(negedge clk);
    check("R1 reset event_cnt", int'(event_cnt), 0);
    check("R1 reset armed", int'(armed), 0);
    check("R1 reset drv_disable", int'(drv_disable), 0);
    check("R1 reset ss_hold", int'(ss_hold), 0);
    check("R1 reset fault_active", int'(fault_active), 0);
    rst_n = 1'b1;

    // R2: no arming or counting until both rail flags are high on a tick
    for (int i = 0; i < 5; i++) cyc(1, 1);
    check("R2 not armed before soft start", int'(armed), 0);
    check("R2 no count before arming", int'(event_cnt), 0);
    ss_done = 1;
    cyc(1, 1);
    check("R2 not armed below half output", int'(armed), 0);
    vout_half = 1;
    cyc(0, 1);
    check("R2 no arming without tick", int'(armed), 0);
    cyc(1, 1);
    check("R2 armed on tick with rails ok", int'(armed), 1);
    check("R2 arming tick not counted", int'(event_cnt), 0);

    // R3 and R11
    for (int i = 0; i < 3; i++) cyc(1, 1);
    check("R3 three hits counted", int'(event_cnt), 3);
    for (int i = 0; i < 6; i++) cyc(0, 1);
    check("R11 no count without tick", int'(event_cnt), 3);

    // R4: three clean ticks are tolerated, four clear
    for (int i = 0; i < 3; i++) cyc(1, 0);
    check("R4 three clean ticks keep count", int'(event_cnt), 3);
    cyc(1, 1);
    check("R4 hit after short clean run continues", int'(event_cnt), 4);
    for (int i = 0; i < 3; i++) begin cyc(1, 0); cyc(0, 0); end
    check("R4 gaps do not break clean run", int'(event_cnt), 4);
    cyc(1, 0);
    check("R4 four clean ticks clear count", int'(event_cnt), 0);

    // R5: reach the trip level
    for (int i = 0; i < TRIP; i++) cyc(1, 1);
    check("R5 count at trip level", int'(event_cnt), TRIP);
    check("R5 not yet shut down", int'(fault_active), 0);
    cyc(0, 0);
    check("R5 shutdown fault_active", int'(fault_active), 1);
    check("R5 shutdown drv_disable", int'(drv_disable), 1);
    check("R5 shutdown ss_hold", int'(ss_hold), 1);
    check("R5 armed dropped", int'(armed), 0);

    // R6: exact off time, with non-tick clocks mixed in (R11)
    for (int i = 0; i < OFFT - 1; i++) begin cyc(1, 1); cyc(0, 0); end
    check("R6 still off before last tick", int'(fault_active), 1);
    check("R11 off time waits for ticks", int'(ss_hold), 1);
    cyc(1, 0);
    check("R6 fault released on last tick", int'(fault_active), 0);
    check("R6 soft start released", int'(ss_hold), 0);
    check("R6 drivers released", int'(drv_disable), 0);

    // R9: restart leaves the block disarmed and cleared
    check("R9 disarmed after restart", int'(armed), 0);
    cyc(0, 0);
    check("R9 count cleared after restart", int'(event_cnt), 0);
    cyc(1, 1);
    check("R9 re-armed by tick", int'(armed), 1);

    // R7: disabled hiccup saturates without shutdown
    hiccup_en = 0;
    for (int i = 0; i < TRIP + 10; i++) cyc(1, 1);
    check("R7 count saturates", int'(event_cnt), TRIP);
    check("R7 no shutdown when disabled", int'(fault_active), 0);

    // R8: enable with full count, then abort the off time
    hiccup_en = 1;
    cyc(0, 0);
    check("R8 shutdown after enable with full count", int'(fault_active), 1);
    for (int i = 0; i < 3; i++) cyc(1, 0);
    hiccup_en = 0;
    cyc(0, 0);
    check("R8 abort waits for tick", int'(fault_active), 1);
    cyc(1, 0);
    check("R8 aborted on next tick", int'(fault_active), 0);
    hiccup_en = 1;

    // R10: rails drop while armed
    cyc(1, 0);
    for (int i = 0; i < 2; i++) cyc(1, 1);
    check("R10 counting before drop", int'(event_cnt), 2);
    vout_half = 0;
    cyc(1, 1);
    check("R10 disarmed on rail drop", int'(armed), 0);
    check("R10 drop tick not counted", int'(event_cnt), 2);
    cyc(0, 0);
    check("R10 count cleared after drop", int'(event_cnt), 0);
    vout_half = 1;

    // constrained random traffic against the reference
    burst = 0;
    for (int i = 0; i < 40000; i++) begin
      if ($urandom_range(0, 99) < 2) burst = ~burst;
      ss_done   = ($urandom_range(0, 99) < 98);
      vout_half = ($urandom_range(0, 99) < 98);
      hiccup_en = ($urandom_range(0, 99) < 95);
      cyc(($urandom_range(0, 1) == 1),
          burst ? ($urandom_range(0, 99) < 92) : ($urandom_range(0, 99) < 25));
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule